// File: doc/BRIEF.md
# Masked Transmit Reset Sequencer

This block controls the internal resets of a serial transmitter. It drives three PMA sub-resets and one PCS reset. A falling edge on the master reset input starts an operation. When the operation starts, the block captures a 3-bit PMA mask, a 1-bit PCS mask and a 2-bit mode. The masks choose which internal resets take part. Each chosen line is asserted when the operation starts and released again later. Lines that are not chosen keep their value.

In sequential mode the chosen lines are released one at a time: PMA bit 2 first, then bit 1, then bit 0, then the PCS line. Each release is followed by a settle window of `SETTLE_CYCLES` clocks. The PCS release waits until the user-ready input is high. The done flag rises at the end of the last settle window. In single mode all chosen lines are released together and done stays low.

Typical settings:

| Use | PMA mask | PCS mask | Mode |
|---|---|---|---|
| Full transmit reset | 111 | 1 | 00 |
| Rate change | 110 | 1 | 00 |
| PCS-only reset | 000 | 1 | 00 or 11 |

Top module: `tx_reset_seq`

## Requirements
- R1: While the synchronous `rst` input is high, the block is idle after the next clock edge. In that state `pmaRst` is 3'b111, `pcsRst` is 1, `done` is 0 and `cfgError` is 0.
- R2: An operation starts at the first clock edge that samples `masterRst` low after it was sampled high. A falling edge seen while an operation is running is ignored.
- R2 (capture and assert): At that start edge the block captures `pmaMask`, `pcsMask` and `mode` for the whole operation. At the same edge it drives high every line whose mask bit is 1.
- R3: Sequential release timing:
  - PMA mask bit j controls `pmaRst[j]`, and `pcsMask` controls `pcsRst`.
  - Release order is `pmaRst[2]`, then `pmaRst[1]`, then `pmaRst[0]`, then `pcsRst`. Unselected stages are skipped and their lines are left unchanged.
  - The first release comes `SETTLE_CYCLES` clocks after the start edge.
  - Each later release comes `SETTLE_CYCLES` clocks after the one before it.
- R4: Mode 2'b11 is single mode. In single mode every selected line is released at the same edge, `SETTLE_CYCLES` clocks after the start edge. Modes 2'b00, 2'b01 and 2'b10 are sequential.
- R5: `done` never rises during an operation run in single mode.
- R6: In sequential mode `pcsRst` is released only at an edge where `userReady` is high. While `userReady` stays low, the sequence waits before the PCS release.
- R7: `done` timing:
  - `done` is cleared at the start edge.
  - In a sequential operation, `done` rises `SETTLE_CYCLES` clocks after the last selected release.
  - A sequential operation with all mask bits 0 sets `done` at its start edge.
  - `done` is never high while an operation is running.
- R8: `cfgError` is set if `pmaMask`, `pcsMask` or `mode` differs from the captured value while an operation runs. It stays set until the next start edge or `rst`. The captured values keep driving the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous global reset, active high |
| masterRst | input | 1 | Master reset; a high-to-low transition starts an operation |
| pmaMask | input | 3 | PMA sub-reset selection; bit j controls pmaRst[j] |
| pcsMask | input | 1 | PCS reset selection |
| mode | input | 2 | 2'b11 single mode, other values sequential |
| userReady | input | 1 | Allows the PCS release in sequential mode |
| pmaRst | output | 3 | PMA sub-reset lines, active high |
| pcsRst | output | 1 | PCS reset line, active high |
| done | output | 1 | Sequential operation finished |
| cfgError | output | 1 | Mask or mode changed during an operation |

## Verification
The assertions check rules that must hold on every cycle:
- the reset state;
- that a PCS release in sequential mode always follows a sampled-high `userReady`;
- that `pmaRst[1]` and `pcsRst` never fall before the lines that come earlier in the order;
- that `done` never rises in single mode and is never high while an operation runs;
- that a configuration change during an operation raises `cfgError`.

Only the bench scenarios can show the exact release cycles for each mask and mode pattern. The same holds for skipping unselected stages, the immediate `done` of an empty sequential operation, the wait for a late `userReady`, and the return to the reset state when `rst` arrives mid-operation.

// File: rtl/txrst_pkg.sv
package txrst_pkg;

  localparam logic [1:0] MODE_SINGLE = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAITUSR
  } stateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;       // capture config, assert selected lines
    logic releaseOne;  // release the next pending stage
    logic releaseAll;  // release every pending stage at once
    logic cntRun;      // advance the settle counter
    logic doneSet;     // raise done
  } strobeT;

endpackage

// File: rtl/txrst_dp.sv
module txrst_dp
  import txrst_pkg::*;
#(
  parameter int PMA_W         = 3,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  strobeT           stb,
  input  logic             busy,
  input  logic [PMA_W-1:0] pmaMask,
  input  logic             pcsMask,
  input  logic [1:0]       mode,
  output logic [PMA_W-1:0] pmaRst,
  output logic             pcsRst,
  output logic             done,
  output logic             cfgError,
  output logic             cntHit,
  output logic             pendEmpty,
  output logic             nextIsPcs,
  output logic             cfgSingle,
  output logic             reqSingle,
  output logic             reqEmpty
);

  localparam int LINES = PMA_W + 1;
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam int CFG_W = PMA_W + 3;

  // Stage-ordered vectors: index 0 is released first, index PMA_W is the PCS
  logic [LINES-1:0] selVec, pending, nextOne, lines;
  logic [CNT_W-1:0] cnt;
  logic [CFG_W-1:0] cfgNow, cfgReg;

  genvar i;
  generate
    for (i = 0; i < PMA_W; i++) begin : g_map
      assign selVec[i]            = pmaMask[PMA_W-1-i];
      assign pmaRst[PMA_W-1-i]    = lines[i];
    end
  endgenerate
  assign selVec[PMA_W] = pcsMask;
  assign pcsRst        = lines[PMA_W];

  // Lowest pending stage as a one-hot vector
  assign nextOne   = pending & (~pending + LINES'(1));
  assign nextIsPcs = nextOne[PMA_W];
  assign pendEmpty = (pending == '0);

  assign cfgNow    = {pmaMask, pcsMask, mode};
  assign cfgSingle = (cfgReg[1:0] == MODE_SINGLE);
  assign reqSingle = (mode == MODE_SINGLE);
  assign reqEmpty  = (selVec == '0);
  assign cntHit    = (cnt == CNT_W'(SETTLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lines    <= '1;
      pending  <= '0;
      cnt      <= '0;
      cfgReg   <= '0;
      done     <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      if (stb.start) begin
        cfgReg   <= cfgNow;
        pending  <= selVec;
        lines    <= lines | selVec;
        cnt      <= '0;
        done     <= 1'b0;
        cfgError <= 1'b0;
      end else begin
        if (busy && (cfgNow != cfgReg)) cfgError <= 1'b1;
        if (stb.releaseAll) begin
          lines   <= lines & ~pending;
          pending <= '0;
        end else if (stb.releaseOne) begin
          lines   <= lines & ~nextOne;
          pending <= pending & ~nextOne;
          cnt     <= '0;
        end else if (stb.cntRun) begin
          cnt <= cnt + CNT_W'(1);
        end
      end
      if (stb.doneSet) done <= 1'b1;
    end
  end

endmodule

// File: rtl/txrst_ctrl.sv
module txrst_ctrl
  import txrst_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   masterRst,
  input  logic   userReady,
  input  logic   cntHit,
  input  logic   pendEmpty,
  input  logic   nextIsPcs,
  input  logic   cfgSingle,
  input  logic   reqSingle,
  input  logic   reqEmpty,
  output strobeT stb,
  output logic   busy
);

  stateT state, stateNxt;
  logic  masterQ;
  logic  masterFall;

  assign masterFall = masterQ & ~masterRst;
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      masterQ <= 1'b0;
    end else begin
      state   <= stateNxt;
      masterQ <= masterRst;
    end
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (masterFall) begin
          stb.start = 1'b1;
          if (!reqSingle && reqEmpty) stb.doneSet = 1'b1;
          else                        stateNxt    = ST_RUN;
        end
      end
      ST_RUN: begin
        stb.cntRun = 1'b1;
        if (cntHit) begin
          if (cfgSingle) begin
            stb.releaseAll = 1'b1;
            stateNxt       = ST_IDLE;
          end else if (pendEmpty) begin
            stb.doneSet = 1'b1;
            stateNxt    = ST_IDLE;
          end else if (nextIsPcs && !userReady) begin
            stateNxt = ST_WAITUSR;
          end else begin
            stb.releaseOne = 1'b1;
          end
        end
      end
      ST_WAITUSR: begin
        if (userReady) begin
          stb.releaseOne = 1'b1;
          stateNxt       = ST_RUN;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tx_reset_seq.sv
module tx_reset_seq
  import txrst_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       masterRst,
  input  logic [2:0] pmaMask,
  input  logic       pcsMask,
  input  logic [1:0] mode,
  input  logic       userReady,
  output logic [2:0] pmaRst,
  output logic       pcsRst,
  output logic       done,
  output logic       cfgError
);

  strobeT stb;
  logic   busy, cntHit, pendEmpty, nextIsPcs, cfgSingle, reqSingle, reqEmpty;

  txrst_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .masterRst (masterRst),
    .userReady (userReady),
    .cntHit    (cntHit),
    .pendEmpty (pendEmpty),
    .nextIsPcs (nextIsPcs),
    .cfgSingle (cfgSingle),
    .reqSingle (reqSingle),
    .reqEmpty  (reqEmpty),
    .stb       (stb),
    .busy      (busy)
  );

  txrst_dp #(
    .PMA_W         (3),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .busy      (busy),
    .pmaMask   (pmaMask),
    .pcsMask   (pcsMask),
    .mode      (mode),
    .pmaRst    (pmaRst),
    .pcsRst    (pcsRst),
    .done      (done),
    .cfgError  (cfgError),
    .cntHit    (cntHit),
    .pendEmpty (pendEmpty),
    .nextIsPcs (nextIsPcs),
    .cfgSingle (cfgSingle),
    .reqSingle (reqSingle),
    .reqEmpty  (reqEmpty)
  );

endmodule

// File: rtl/tx_reset_seq_chk.sv
module tx_reset_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       masterRst,
  input logic [2:0] pmaMask,
  input logic       pcsMask,
  input logic [1:0] mode,
  input logic       userReady,
  input logic [2:0] pmaRst,
  input logic       pcsRst,
  input logic       done,
  input logic       cfgError,
  input logic       busy
);

  // Checker-side model of the operation context
  logic       mQ, opSingle;
  logic [5:0] cfgC;
  logic       startSeen;

  assign startSeen = mQ && !masterRst && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mQ       <= 1'b0;
      opSingle <= 1'b0;
      cfgC     <= '0;
    end else begin
      mQ <= masterRst;
      if (startSeen) begin
        opSingle <= (mode == 2'b11);
        cfgC     <= {pmaMask, pcsMask, mode};
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pmaRst == 3'b111 && pcsRst && !done && !cfgError));

  assert_pcs_gate_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(pcsRst) && !opSingle) |-> $past(userReady));

  assert_single_nodone_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !opSingle);

  assert_order_pma1_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(pmaRst[1]) && !opSingle && cfgC[5]) |-> !pmaRst[2]);

  assert_order_pcs_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(pcsRst) && !opSingle) |-> ((pmaRst & cfgC[5:3]) == 3'b000));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_cfg_error_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && ({pmaMask, pcsMask, mode} != cfgC)) |=> cfgError);

endmodule

bind tx_reset_seq tx_reset_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .masterRst (masterRst),
  .pmaMask   (pmaMask),
  .pcsMask   (pcsMask),
  .mode      (mode),
  .userReady (userReady),
  .pmaRst    (pmaRst),
  .pcsRst    (pcsRst),
  .done      (done),
  .cfgError  (cfgError),
  .busy      (busy)
);

// File: tb/tx_reset_seq_bench.sv
module tx_reset_seq_bench;

  localparam int S      = 4;
  localparam int WIN    = 40;
  localparam int NEVER  = 63;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       masterRst = 1'b0;
  logic [2:0] pmaMask = 3'b000;
  logic       pcsMask = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       userReady = 1'b1;
  logic [2:0] pmaRst;
  logic       pcsRst, done, cfgError;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // Observed results of one operation (cycle index k after the start edge)
  int relP2, relP1, relP0, relPc, doneAt, errAt;
  logic errAt0;

  always #10 clk = ~clk;  // 50 MHz

  tx_reset_seq #(.SETTLE_CYCLES(S)) u_tx_reset_seq (
    .clk       (clk),
    .rst       (rst),
    .masterRst (masterRst),
    .pmaMask   (pmaMask),
    .pcsMask   (pcsMask),
    .mode      (mode),
    .userReady (userReady),
    .pmaRst    (pmaRst),
    .pcsRst    (pcsRst),
    .done      (done),
    .cfgError  (cfgError)
  );

  typedef struct packed {
    logic [2:0] pm;
    logic       pc;
    logic [1:0] md;
    logic [5:0] eP2;
    logic [5:0] eP1;
    logic [5:0] eP0;
    logic [5:0] ePc;
    logic [5:0] eDone;
  } vecT;

  // Every row follows a row that left all lines released
  localparam vecT TBL [8] = '{
    '{3'b111, 1'b1, 2'b00, 6'd4, 6'd8, 6'd12, 6'd16, 6'd20},  // full, sequential
    '{3'b110, 1'b1, 2'b00, 6'd4, 6'd8, 6'd0,  6'd12, 6'd16},  // rate change
    '{3'b000, 1'b1, 2'b00, 6'd0, 6'd0, 6'd0,  6'd4,  6'd8},   // PCS only, seq
    '{3'b000, 1'b1, 2'b11, 6'd0, 6'd0, 6'd0,  6'd4,  6'd63},  // PCS only, single
    '{3'b111, 1'b1, 2'b11, 6'd4, 6'd4, 6'd4,  6'd4,  6'd63},  // full, single
    '{3'b101, 1'b0, 2'b01, 6'd4, 6'd0, 6'd8,  6'd0,  6'd12},  // mode 01 seq
    '{3'b011, 1'b0, 2'b10, 6'd0, 6'd4, 6'd8,  6'd0,  6'd12},  // mode 10 seq
    '{3'b000, 1'b0, 2'b00, 6'd0, 6'd0, 6'd0,  6'd0,  6'd0}    // empty seq
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Start one operation and watch WIN cycles. urLowUntil >= 0 holds userReady
  // low until after sample k=urLowUntil; flipAt >= 0 toggles pmaMask[0] for one cycle.
  task automatic runOp(input logic [2:0] pm, input logic pc, input logic [1:0] md,
                       input int urLowUntil, input int flipAt);
    relP2 = NEVER; relP1 = NEVER; relP0 = NEVER; relPc = NEVER;
    doneAt = NEVER; errAt = NEVER;
    @(negedge clk);
    masterRst = 1'b1;
    pmaMask = pm; pcsMask = pc; mode = md;
    userReady = (urLowUntil < 0);
    @(negedge clk);
    masterRst = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      if (k == 0) errAt0 = cfgError;
      if (!pmaRst[2] && relP2 == NEVER) relP2 = k;
      if (!pmaRst[1] && relP1 == NEVER) relP1 = k;
      if (!pmaRst[0] && relP0 == NEVER) relP0 = k;
      if (!pcsRst    && relPc == NEVER) relPc = k;
      if (done   && doneAt == NEVER) doneAt = k;
      if (cfgError && errAt == NEVER) errAt = k;
      if (k == urLowUntil) userReady = 1'b1;
      if (k == flipAt) pmaMask = pm ^ 3'b001;
      if (k == flipAt + 1) pmaMask = pm;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        finishRun();
      end
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pmaRst == 3'b111 && pcsRst && !done && !cfgError, "R1 reset state",
          {pmaRst, pcsRst, done, cfgError}, 6'b111100);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R2: no operation without a falling edge
    check(pmaRst == 3'b111 && pcsRst && !done, "R2 idle without edge",
          {pmaRst, pcsRst, done}, 5'b11110);

    // Table walk: R3 order/skip, R4 modes, R5 single no done, R7 done timing
    for (int i = 0; i < 8; i++) begin
      runOp(TBL[i].pm, TBL[i].pc, TBL[i].md, -1, -1);
      check(relP2 == int'(TBL[i].eP2), $sformatf("R3 row%0d pmaRst[2] release", i), relP2, TBL[i].eP2);
      check(relP1 == int'(TBL[i].eP1), $sformatf("R3 row%0d pmaRst[1] release", i), relP1, TBL[i].eP1);
      check(relP0 == int'(TBL[i].eP0), $sformatf("R4 row%0d pmaRst[0] release", i), relP0, TBL[i].eP0);
      check(relPc == int'(TBL[i].ePc), $sformatf("R4 row%0d pcsRst release", i), relPc, TBL[i].ePc);
      check(doneAt == int'(TBL[i].eDone), $sformatf("R7/R5 row%0d done cycle", i), doneAt, TBL[i].eDone);
    end

    // R2: selected lines assert at the start edge (after all released)
    @(negedge clk);
    masterRst = 1'b1;
    pmaMask = 3'b010; pcsMask = 1'b1; mode = 2'b00; userReady = 1'b1;
    @(negedge clk);
    masterRst = 1'b0;
    @(negedge clk);
    check(pmaRst == 3'b010 && pcsRst && !done, "R2 selected lines asserted",
          {pmaRst, pcsRst, done}, 5'b01010);
    repeat (20) @(negedge clk);

    // R6: PCS release waits for userReady
    runOp(3'b111, 1'b1, 2'b00, 22, -1);
    check(relP0 == 12, "R6 pma stages unaffected", relP0, 12);
    check(relPc == 23, "R6 pcsRst waits for userReady", relPc, 23);
    check(doneAt == 27, "R6 done after late PCS release", doneAt, 27);

    // R8: mask change mid-operation sets cfgError; captured config still used
    runOp(3'b111, 1'b1, 2'b00, -1, 5);
    check(errAt == 6, "R8 cfgError cycle", errAt, 6);
    check(relP0 == 12 && relPc == 16, "R8 captured masks drive sequence", relP0, 12);
    check(cfgError == 1'b1, "R8 cfgError sticky", cfgError, 1);
    runOp(3'b000, 1'b1, 2'b00, -1, -1);
    check(errAt0 == 1'b0, "R8 cfgError cleared at start", errAt0, 0);

    // R1: global reset in the middle of an operation
    @(negedge clk);
    masterRst = 1'b1; pmaMask = 3'b111; pcsMask = 1'b1; mode = 2'b00;
    @(negedge clk);
    masterRst = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pmaRst == 3'b111 && pcsRst && !done && !cfgError, "R1 reset mid-operation",
          {pmaRst, pcsRst, done, cfgError}, 6'b111100);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(pmaRst == 3'b111 && pcsRst && !done, "R1 stays idle after reset",
          {pmaRst, pcsRst, done}, 5'b11110);

    finishRun();
  end

endmodule